// File: doc/BRIEF.md
# Column-Cover Reduction and Selection Engine

This engine carries out the inner step of an exact minimum column-cover search on a binary matrix. The matrix lives in an external store that can be read one row or one column at a time. The current branch is described by two mask vectors, one for rows and one for columns. A set bit marks a row or column that has been removed. On a start pulse the engine loads both masks. If asked, it first takes a chosen column into the cover. It then builds a ones count for every remaining row and applies the reduction rules until a full pass changes nothing.

Once reduction is stable, the engine classifies the branch. The branch is solved when no row remains. It has no cover when a remaining row is empty. It is pruned when the partial cover can no longer beat the best cover found so far. Otherwise the engine names the row to branch on, the leftmost candidate column in that row, and that row's ones count, which is the number of branches. The updated masks are returned so that the surrounding recursion can stack and restore them.

Top module: `ccr_engine`

## Requirements
- R1: A `start` pulse while idle loads `row_mask_in` and `col_mask_in` into `row_mask` and `col_mask` (bit set = removed) and raises `busy`. The result is marked by `done` high for exactly one cycle with `busy` low. A `start` pulse while `busy` is high has no effect.
- R2: For two distinct live rows a and b, if (row a AND row b) over live columns equals row b, then row a is removed. Of two identical rows, the one with the lower index is removed.
- R3: A live column with no 1 among live rows is removed. For two distinct live columns a and b, if (column a AND column b) over live rows equals column a, then column a is removed. Of two identical columns, the one with the lower index is removed.
- R4: Each live row's count equals its number of 1s in live columns. Removing a column decrements the count of each live row that has a 1 in it, and removing a row zeroes its count. Reduction passes repeat until one full pass removes nothing.
- R5: If no live row remains after reduction, `status` = 1 (solved).
- R6: Else, if a live row has count 0, `status` = 2 (no cover).
- R7: Else, if `best_valid` is set and `cover_size` + 1 >= `best_size`, `status` = 3 (pruned).
- R8: Else the topmost live row with the fewest ones is selected. `sel_row` is its index, `sel_count` is its count and `sel_col` is its lowest-index live column holding a 1. `status` = 4 (forced) when the count is 1 and 5 (branch) otherwise.
- R9: With `take_en` high at start, column `take_col` and every live row with a 1 in it are removed before counting and reduction.
- R10: The store returns on `row_rdata` (bit c = column c) or `col_rdata` (bit r = row r) the word for the address held at a rising edge, valid after that edge.
- R11: After reset `busy`, `done`, `status`, `row_mask` and `col_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one reduction and selection step |
| take_en | input | 1 | Take `take_col` into the cover first |
| take_col | input | CIW | Column to take |
| row_mask_in | input | NR | Initial row mask, 1 = removed |
| col_mask_in | input | NC | Initial column mask, 1 = removed |
| cover_size | input | SZW | Size of partial cover, including a taken column |
| best_size | input | SZW | Size of best cover so far |
| best_valid | input | 1 | A best cover exists |
| row_addr | output | RIW | Row address to the store |
| row_rdata | input | NC | Row word from the store |
| col_addr | output | CIW | Column address to the store |
| col_rdata | input | NR | Column word from the store |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Outcome code (R5 to R8) |
| sel_row | output | RIW | Selected row |
| sel_col | output | CIW | First candidate column |
| sel_count | output | CNW | Ones in selected row (branch count) |
| row_mask | output | NR | Current row mask |
| col_mask | output | NC | Current column mask |

## Verification
The matrices are chosen so that each one isolates a single rule. A row contained in another separates row subsumption from column removal. A cyclic set of pairs plus one wide row has no subsumption at all, so it shows the fewest-ones rule picking a row below a wider one. A chained matrix needs four passes, and each removal there uncovers the next, so it exposes a single-pass engine and stale counts. The prune bound is tried on both sides of its edge. A take step and a start pulse sent while busy use the same matrix, so their effects can be compared directly.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    ST_NONE    = 3'd0,
    ST_SOLVED  = 3'd1,
    ST_NOCOVER = 3'd2,
    ST_PRUNED  = 3'd3,
    ST_FORCED  = 3'd4,
    ST_BRANCH  = 3'd5
  } ccr_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_TAKE, S_CNT, S_RI, S_RJ, S_CI, S_CJ, S_EVAL, S_SEL
  } ccr_state_e;
endpackage

// File: rtl/ccr_cnt_file.sv
module ccr_cnt_file #(
  parameter int NR  = 8,
  parameter int NC  = 8,
  parameter int RIW = 3,
  parameter int CNW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [RIW-1:0]    ld_idx,
  input  logic [NC-1:0]     ld_bits,
  input  logic              ld_zero,
  input  logic [NR-1:0]     clr,
  input  logic [NR-1:0]     dec,
  output logic [NR*CNW-1:0] cnt_flat
);
  logic [CNW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int c = 0; c < NC; c++) ones = ones + CNW'(ld_bits[c]);
  end

  for (genvar r = 0; r < NR; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst || clr[r])
        cnt_flat[r*CNW +: CNW] <= '0;
      else if (ld_en && ld_idx == RIW'(r))
        cnt_flat[r*CNW +: CNW] <= ld_zero ? '0 : ones;
      else if (dec[r])
        cnt_flat[r*CNW +: CNW] <= cnt_flat[r*CNW +: CNW] - 1'b1;
    end
  end
endmodule

// File: rtl/ccr_row_pick.sv
module ccr_row_pick #(
  parameter int NR  = 8,
  parameter int RIW = 3,
  parameter int CNW = 4
) (
  input  logic [NR*CNW-1:0] cnt_flat,
  input  logic [NR-1:0]     live,
  output logic              any_live,
  output logic              any_empty,
  output logic [RIW-1:0]    pick_idx,
  output logic [CNW-1:0]    pick_cnt
);
  logic [CNW-1:0] c;

  always_comb begin
    any_live  = 1'b0;
    any_empty = 1'b0;
    pick_idx  = '0;
    pick_cnt  = '1;
    c         = '0;
    for (int r = 0; r < NR; r++) begin
      c = cnt_flat[r*CNW +: CNW];
      if (live[r]) begin
        if (c == '0) any_empty = 1'b1;
        if (!any_live || c < pick_cnt) begin
          pick_cnt = c;
          pick_idx = RIW'(r);
        end
        any_live = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccr_first_one.sv
module ccr_first_one #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/ccr_engine.sv
module ccr_engine
  import ccr_pkg::*;
#(
  parameter  int NR  = 8,
  parameter  int NC  = 8,
  localparam int RIW = (NR > 1) ? $clog2(NR) : 1,
  localparam int CIW = (NC > 1) ? $clog2(NC) : 1,
  localparam int CNW = $clog2(NC + 1),
  localparam int SZW = $clog2(NC + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           take_en,
  input  logic [CIW-1:0] take_col,
  input  logic [NR-1:0]  row_mask_in,
  input  logic [NC-1:0]  col_mask_in,
  input  logic [SZW-1:0] cover_size,
  input  logic [SZW-1:0] best_size,
  input  logic           best_valid,
  output logic [RIW-1:0] row_addr,
  input  logic [NC-1:0]  row_rdata,
  output logic [CIW-1:0] col_addr,
  input  logic [NR-1:0]  col_rdata,
  output logic           busy,
  output logic           done,
  output logic [2:0]     status,
  output logic [RIW-1:0] sel_row,
  output logic [CIW-1:0] sel_col,
  output logic [CNW-1:0] sel_count,
  output logic [NR-1:0]  row_mask,
  output logic [NC-1:0]  col_mask
);
  ccr_state_e     st;
  ccr_status_e    res;
  logic [1:0]     ph;
  logic [RIW-1:0] ri, rj;
  logic [CIW-1:0] ci, cj, take_q;
  logic [NC-1:0]  hold_r;
  logic [NR-1:0]  hold_c;
  logic           changed, best_v_q;
  logic [SZW-1:0] cover_q, best_q;

  logic [NR*CNW-1:0] cnt_flat;
  logic [NR-1:0]     clr_v, dec_v;
  logic              ld_en, any_live, any_empty, prune;
  logic [RIW-1:0]    pick_idx;
  logic [CNW-1:0]    pick_cnt;
  logic [CIW-1:0]    first_col;
  logic              row_sub, col_sub, col_zero, ri_last, rj_last, ci_last, cj_last;

  assign status   = res;
  assign ri_last  = (ri == RIW'(NR - 1));
  assign rj_last  = (rj == RIW'(NR - 1));
  assign ci_last  = (ci == CIW'(NC - 1));
  assign cj_last  = (cj == CIW'(NC - 1));
  assign row_sub  = ((hold_r & row_rdata & ~col_mask) == (row_rdata & ~col_mask));
  assign col_sub  = ((hold_c & col_rdata & ~row_mask) == (hold_c & ~row_mask));
  assign col_zero = ((col_rdata & ~row_mask) == '0);
  assign prune    = best_v_q && ({1'b0, cover_q} + 1'b1 >= {1'b0, best_q});

  always_comb begin
    ld_en = (st == S_CNT) && (ph == 2'd2);
    clr_v = '0;
    dec_v = '0;
    if (st == S_RJ && ph == 2'd2 && row_sub) clr_v[ri] = 1'b1;
    if (st == S_CJ && ph == 2'd2 && col_sub) dec_v = hold_c & ~row_mask;
  end

  ccr_cnt_file #(.NR(NR), .NC(NC), .RIW(RIW), .CNW(CNW)) u_cnt (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ri),
    .ld_bits(row_rdata & ~col_mask), .ld_zero(row_mask[ri]),
    .clr(clr_v), .dec(dec_v), .cnt_flat(cnt_flat));

  ccr_row_pick #(.NR(NR), .RIW(RIW), .CNW(CNW)) u_pick (
    .cnt_flat(cnt_flat), .live(~row_mask), .any_live(any_live),
    .any_empty(any_empty), .pick_idx(pick_idx), .pick_cnt(pick_cnt));

  ccr_first_one #(.W(NC), .IW(CIW)) u_first (
    .vec(row_rdata & ~col_mask), .idx(first_col));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; res <= ST_NONE; ph <= '0; busy <= 1'b0; done <= 1'b0;
      ri <= '0; rj <= '0; ci <= '0; cj <= '0; take_q <= '0;
      hold_r <= '0; hold_c <= '0; changed <= 1'b0;
      best_v_q <= 1'b0; cover_q <= '0; best_q <= '0;
      row_addr <= '0; col_addr <= '0; sel_row <= '0; sel_col <= '0; sel_count <= '0;
      row_mask <= '0; col_mask <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          row_mask <= row_mask_in; col_mask <= col_mask_in;
          cover_q <= cover_size; best_q <= best_size; best_v_q <= best_valid;
          take_q <= take_col; res <= ST_NONE; busy <= 1'b1;
          ri <= '0; ph <= '0; st <= take_en ? S_TAKE : S_CNT;
        end
        S_TAKE:
          if (ph == 2'd0) begin col_addr <= take_q; ph <= 2'd1; end
          else if (ph == 2'd1) ph <= 2'd2;
          else begin
            row_mask <= row_mask | col_rdata;
            col_mask[take_q] <= 1'b1;
            ph <= '0; st <= S_CNT;
          end
        S_CNT:
          if (ph == 2'd0) begin row_addr <= ri; ph <= 2'd1; end
          else if (ph == 2'd1) ph <= 2'd2;
          else begin
            ph <= '0;
            if (ri_last) begin ri <= '0; changed <= 1'b0; st <= S_RI; end
            else ri <= ri + 1'b1;
          end
        S_RI:
          if (ph == 2'd0) begin
            if (row_mask[ri]) begin
              if (ri_last) begin ci <= '0; st <= S_CI; end else ri <= ri + 1'b1;
            end else begin row_addr <= ri; ph <= 2'd1; end
          end else if (ph == 2'd1) ph <= 2'd2;
          else begin hold_r <= row_rdata; rj <= '0; ph <= '0; st <= S_RJ; end
        S_RJ:
          if (ph == 2'd0) begin
            if (rj == ri || row_mask[rj]) begin
              if (!rj_last) rj <= rj + 1'b1;
              else if (ri_last) begin ci <= '0; st <= S_CI; end
              else begin ri <= ri + 1'b1; st <= S_RI; end
            end else begin row_addr <= rj; ph <= 2'd1; end
          end else if (ph == 2'd1) ph <= 2'd2;
          else begin
            ph <= '0;
            if (row_sub) begin row_mask[ri] <= 1'b1; changed <= 1'b1; end
            if (!row_sub && !rj_last) rj <= rj + 1'b1;
            else if (ri_last) begin ci <= '0; st <= S_CI; end
            else begin ri <= ri + 1'b1; st <= S_RI; end
          end
        S_CI:
          if (ph == 2'd0) begin
            if (col_mask[ci]) begin
              if (!ci_last) ci <= ci + 1'b1;
              else if (changed) begin changed <= 1'b0; ri <= '0; st <= S_RI; end
              else st <= S_EVAL;
            end else begin col_addr <= ci; ph <= 2'd1; end
          end else if (ph == 2'd1) ph <= 2'd2;
          else begin
            ph <= '0;
            if (col_zero) begin
              col_mask[ci] <= 1'b1; changed <= 1'b1;
              if (!ci_last) ci <= ci + 1'b1;
              else begin changed <= 1'b0; ri <= '0; st <= S_RI; end
            end else begin hold_c <= col_rdata; cj <= '0; st <= S_CJ; end
          end
        S_CJ:
          if (ph == 2'd0) begin
            if (cj == ci || col_mask[cj]) begin
              if (!cj_last) cj <= cj + 1'b1;
              else if (!ci_last) begin ci <= ci + 1'b1; st <= S_CI; end
              else if (changed) begin changed <= 1'b0; ri <= '0; st <= S_RI; end
              else st <= S_EVAL;
            end else begin col_addr <= cj; ph <= 2'd1; end
          end else if (ph == 2'd1) ph <= 2'd2;
          else begin
            ph <= '0;
            if (col_sub) col_mask[ci] <= 1'b1;
            if (!col_sub && !cj_last) cj <= cj + 1'b1;
            else if (!ci_last) begin
              ci <= ci + 1'b1; st <= S_CI;
              if (col_sub) changed <= 1'b1;
            end else if (changed || col_sub) begin changed <= 1'b0; ri <= '0; st <= S_RI; end
            else st <= S_EVAL;
          end
        S_EVAL:
          if (!any_live || any_empty || prune) begin
            res <= !any_live ? ST_SOLVED : (any_empty ? ST_NOCOVER : ST_PRUNED);
            busy <= 1'b0; done <= 1'b1; st <= S_IDLE;
          end else begin
            sel_row <= pick_idx; sel_count <= pick_cnt; row_addr <= pick_idx;
            ph <= 2'd1; st <= S_SEL;
          end
        S_SEL:
          if (ph == 2'd1) ph <= 2'd2;
          else begin
            sel_col <= first_col;
            res <= (sel_count == CNW'(1)) ? ST_FORCED : ST_BRANCH;
            ph <= '0; busy <= 1'b0; done <= 1'b1; st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccr_engine_chk.sv
module ccr_engine_chk #(
  parameter  int NR  = 8,
  parameter  int NC  = 8,
  localparam int RIW = (NR > 1) ? $clog2(NR) : 1,
  localparam int CIW = (NC > 1) ? $clog2(NC) : 1,
  localparam int CNW = $clog2(NC + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic [2:0]     status,
  input logic [RIW-1:0] sel_row,
  input logic [CIW-1:0] sel_col,
  input logic [CNW-1:0] sel_count,
  input logic [NR-1:0]  row_mask,
  input logic [NC-1:0]  col_mask
);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r4_rows_grow: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((row_mask & $past(row_mask)) == $past(row_mask)));
  a_r4_cols_grow: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((col_mask & $past(col_mask)) == $past(col_mask)));
  a_r8_forced_one: assert property (@(posedge clk) disable iff (rst)
    (done && status == 3'd4) |-> (sel_count == CNW'(1)));
  a_r8_branch_many: assert property (@(posedge clk) disable iff (rst)
    (done && status == 3'd5) |-> (sel_count > CNW'(1)));
  a_r8_sel_live: assert property (@(posedge clk) disable iff (rst)
    (done && (status == 3'd4 || status == 3'd5)) |-> (!row_mask[sel_row] && !col_mask[sel_col]));
endmodule

bind ccr_engine ccr_engine_chk #(.NR(NR), .NC(NC)) u_ccr_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .status(status),
  .sel_row(sel_row), .sel_col(sel_col), .sel_count(sel_count),
  .row_mask(row_mask), .col_mask(col_mask));

// File: tb/test_ccr_engine.sv
module test_ccr_engine;
  localparam int NR = 8, NC = 8;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, take_en = 1'b0, best_valid = 1'b0;
  logic [2:0] take_col = '0;
  logic [NR-1:0] row_mask_in = '0;
  logic [NC-1:0] col_mask_in = '0;
  logic [3:0] cover_size = '0, best_size = '0;
  logic [2:0] row_addr, col_addr, sel_row, sel_col, status;
  logic [NC-1:0] row_rdata;
  logic [NR-1:0] col_rdata;
  logic busy, done;
  logic [3:0] sel_count;
  logic [NR-1:0] row_mask;
  logic [NC-1:0] col_mask;
  logic [NC-1:0] mat [NR];
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    row_rdata <= mat[row_addr];
    for (int r = 0; r < NR; r++) col_rdata[r] <= mat[r][col_addr];
  end

  ccr_engine #(.NR(NR), .NC(NC)) i_ccr_engine (
    .clk(clk), .rst(rst), .start(start), .take_en(take_en), .take_col(take_col),
    .row_mask_in(row_mask_in), .col_mask_in(col_mask_in), .cover_size(cover_size),
    .best_size(best_size), .best_valid(best_valid), .row_addr(row_addr),
    .row_rdata(row_rdata), .col_addr(col_addr), .col_rdata(col_rdata),
    .busy(busy), .done(done), .status(status), .sel_row(sel_row), .sel_col(sel_col),
    .sel_count(sel_count), .row_mask(row_mask), .col_mask(col_mask));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [NC-1:0] r0, r1, r2, r3);
    for (int r = 0; r < NR; r++) mat[r] = '0;
    mat[0] = r0; mat[1] = r1; mat[2] = r2; mat[3] = r3;
  endtask

  task automatic run(input logic [NR-1:0] rm, input logic [NC-1:0] cm, input logic tk,
                     input logic [2:0] tc, input logic bv, input logic [3:0] cs, bs,
                     input bit poke);
    @(negedge clk);
    row_mask_in = rm; col_mask_in = cm; take_en = tk; take_col = tc;
    best_valid = bv; cover_size = cs; best_size = bs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      row_mask_in = '1; take_en = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R1: watchdog, actual done 0 expected 1");
    end
  endtask

  task automatic t_reset;
    check("R11 busy", busy, 0); check("R11 done", done, 0);
    check("R11 status", status, 0); check("R11 row_mask", row_mask, 0);
    check("R11 col_mask", col_mask, 0);
  endtask

  task automatic t_solved;
    load(8'h07, 8'h03, 8'h00, 8'h00);
    run(8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
    check("R5 status", status, 1);
    @(negedge clk);
    check("R1 done one cycle", done, 0);
  endtask

  task automatic t_nocover;
    load(8'h00, 8'h00, 8'h00, 8'h00);
    run(8'hFE, 8'h00, 0, 0, 0, 0, 0, 0);
    check("R6 status", status, 2);
    check("R3 zero columns removed", col_mask, 8'hFF);
  endtask

  task automatic t_rowsub;
    load(8'h07, 8'h03, 8'h00, 8'h00);
    run(8'hFC, 8'h00, 0, 0, 0, 0, 0, 0);
    check("R2 row_mask", row_mask, 8'hFD);
    check("R3 col_mask", col_mask, 8'hFD);
    check("R4 count after column removal", sel_count, 1);
    check("R8 forced status", status, 4);
    check("R8 sel_row", sel_row, 1);
    check("R10 sel_col via store read", sel_col, 1);
  endtask

  task automatic t_iterate;
    load(8'h07, 8'h09, 8'h0A, 8'h14);
    run(8'hF0, 8'hE0, 0, 0, 0, 0, 0, 0);
    check("R4 row_mask after passes", row_mask, 8'hF3);
    check("R4 col_mask after passes", col_mask, 8'hF3);
    check("R8 status", status, 4);
    check("R8 sel_row topmost", sel_row, 2);
    check("R8 sel_col", sel_col, 3);
  endtask

  task automatic t_branch;
    load(8'h07, 8'h09, 8'h0A, 8'h0C);
    run(8'hF0, 8'hF0, 0, 0, 0, 0, 0, 0);
    check("R8 branch status", status, 5);
    check("R8 fewest-ones row", sel_row, 1);
    check("R8 leftmost col", sel_col, 0);
    check("R8 branch count", sel_count, 2);
    check("R2 no row removed", row_mask, 8'hF0);
  endtask

  task automatic t_prune;
    load(8'h07, 8'h09, 8'h0A, 8'h0C);
    run(8'hF0, 8'hF0, 0, 0, 1, 1, 2, 0);
    check("R7 pruned at bound", status, 3);
    run(8'hF0, 8'hF0, 0, 0, 1, 1, 3, 0);
    check("R7 not pruned below bound", status, 5);
  endtask

  task automatic t_take;
    load(8'h07, 8'h09, 8'h0A, 8'h0C);
    run(8'hF0, 8'hF0, 1, 3, 0, 1, 0, 0);
    check("R9 row_mask", row_mask, 8'hFE);
    check("R9 col_mask", col_mask, 8'hFB);
    check("R9 status", status, 4);
    check("R9 sel_col", sel_col, 2);
  endtask

  task automatic t_busy_ignore;
    load(8'h07, 8'h09, 8'h0A, 8'h0C);
    run(8'hF0, 8'hF0, 0, 0, 0, 0, 0, 1);
    check("R1 start while busy ignored status", status, 5);
    check("R1 start while busy ignored mask", row_mask, 8'hF0);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) mat[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_solved;
    t_nocover;
    t_rowsub;
    t_iterate;
    t_branch;
    t_prune;
    t_take;
    t_busy_ignore;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule